// File: doc/BRIEF.md
# Externally Strobed Parallel FIFO Port

This block is a 16-bit parallel data port. An external device supplies the only transfer clock, a single strobe line that also acts as the chip select. Inside the chip, the port holds two FIFOs. The transmit FIFO is filled by the CPU or a DMA engine and emptied by the external device. The receive FIFO is filled by the external device and drained by the CPU or DMA. All internal logic runs on the system clock. The strobe line is asynchronous to that clock, so it is brought into the system clock domain through a synchronizer and turned into one single-cycle event per rising edge. The direction line and the inbound data word travel through the same pipeline, so they stay aligned with the event.

On each strobe event the sampled direction line selects the transfer type. A high level means the external device reads. The port then pops the next transmit word, registers it onto the outbound bus and enables the output driver. A low level means the external device writes. The inbound word is pushed into the receive FIFO. The write path has no flow control. When a write meets a full receive FIFO, the word is dropped and a sticky overflow flag is set. Software clears that flag with a write-one-to-clear pulse, and an enable input gates it onto the interrupt line. A read-request flag tells the external device whether transmit data is available. It falls on the same system clock edge that pops the last transmit word. It rises one system clock after the transmit FIFO stops being empty.

Top module: `strobe_fifo_port`

## Requirements
- R1: During and after a synchronous reset, ext_rd_req, ext_dout_en, ovf_flag and ovf_irq are 0, both FIFOs report empty with level 0, and neither reports full.
- R2: One rising edge of ext_strb produces exactly one transfer, however long the strobe stays high.
- R3: A strobe edge with ext_dir = 1 while ext_rd_req = 1 pops one transmit word on the third system clock edge after the strobe rises. On that edge ext_dout carries the word, in push order, and ext_dout_en goes to 1. Any later strobe event that is not an accepted read drives ext_dout_en back to 0.
- R4: ext_rd_req goes to 0 on the same system clock edge that pops the last transmit word, and it stays 1 on the edge before.
- R5: After a push into an empty transmit FIFO, ext_rd_req is still 0 in the cycle that follows that push, and it is 1 one cycle later.
- R6: A read strobe (ext_dir = 1) seen while ext_rd_req = 0 pops nothing and leaves ext_dout_en at 0.
- R7: A strobe edge with ext_dir = 0 pushes ext_din into the receive FIFO on the third system clock edge after the strobe rises. rx_rdata shows the oldest word, and rx_level counts the stored words up to 16, at which point rx_full is 1.
- R8: A write strobe that meets a full receive FIFO sets ovf_flag and discards the word. The level and the stored words stay unchanged.
- R9: ovf_flag stays set until ovf_clr is pulsed. A set and a clear in the same cycle leave the flag set. ovf_irq equals ovf_flag when ovf_en = 1 and is 0 when ovf_en = 0.
- R10: A push into the full transmit FIFO is ignored, and a pop from the empty receive FIFO is ignored. tx_level counts from 0 to 16, and tx_full is 1 exactly at 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_strb | input | 1 | External strobe / chip select, asynchronous |
| ext_dir | input | 1 | Transfer direction: 1 = external read, 0 = external write |
| ext_din | input | 16 | Inbound data from the external device |
| ext_dout | output | 16 | Outbound data to the external device |
| ext_dout_en | output | 1 | Output driver enable for ext_dout |
| ext_rd_req | output | 1 | Transmit data available to the external device |
| tx_push | input | 1 | Push ext-bound word (system side) |
| tx_wdata | input | 16 | Word to push into the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_level | output | 5 | Words held in the transmit FIFO |
| rx_pop | input | 1 | Pop the oldest received word |
| rx_rdata | output | 16 | Oldest received word |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_level | output | 5 | Words held in the receive FIFO |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |
| ovf_en | input | 1 | Overflow interrupt enable |
| ovf_flag | output | 1 | Sticky receive overflow status |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
For every fill depth from 1 to 16, the bench fills the transmit FIFO and then drains it with external reads. At each read it checks the request flag on the edge before the last pop and on the pop edge itself. A design whose flag drops one cycle late would let the external device issue a read into an empty FIFO. The bench holds the strobe high for many cycles to catch a level-sensitive detector, which would pop several words at once. It sends read strobes while the request flag is low, where a missing gate would pop garbage or enable the driver. It writes into a full receive FIFO and then reads the contents back in full. A design that overwrote the tail or advanced a pointer would show a corrupted word there, and a lost overflow flag would show as a silent drop.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

    localparam int PFP_DATA_W = 16;
    localparam int PFP_DEPTH  = 16;
    localparam int PFP_SYNC   = 2;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } xfer_dir_e;

    function automatic int level_bits(input int depth);
        return $clog2(depth) + 1;
    endfunction

endpackage

// File: rtl/pfp_fifo.sv
module pfp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int LW    = pfp_pkg::level_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    assign rdata = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == LW'(DEPTH));
    assign level = cnt;

endmodule

// File: rtl/pfp_strobe_sync.sv
module pfp_strobe_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strb_async,
    input  logic               dir_async,
    input  logic [W-1:0]       data_async,
    output logic               evt_valid,
    output pfp_pkg::xfer_dir_e evt_dir,
    output logic [W-1:0]       evt_data
);
    typedef struct packed {
        logic         strb;
        logic         dir;
        logic [W-1:0] data;
    } samp_t;

    samp_t [STAGES-1:0] stage;
    samp_t              cur;
    logic               strb_prev;

    assign cur = '{strb: strb_async, dir: dir_async, data: data_async};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= '0;
            strb_prev <= 1'b0;
        end else begin
            stage     <= {stage[STAGES-2:0], cur};
            strb_prev <= stage[STAGES-1].strb;
        end
    end

    assign evt_valid = stage[STAGES-1].strb & ~strb_prev;
    assign evt_dir   = pfp_pkg::xfer_dir_e'(stage[STAGES-1].dir);
    assign evt_data  = stage[STAGES-1].data;

endmodule

// File: rtl/pfp_tx_drive.sv
module pfp_tx_drive #(
    parameter int W  = 16,
    parameter int LW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    input  pfp_pkg::xfer_dir_e evt_dir,
    input  logic [W-1:0]       tx_head,
    input  logic               tx_empty,
    input  logic [LW-1:0]      tx_level,
    input  logic               tx_push_ok,
    output logic               tx_pop,
    output logic               rd_req,
    output logic [W-1:0]       dout,
    output logic               dout_en
);
    logic accept, last_out, req_d;

    assign accept   = evt_valid & (evt_dir == pfp_pkg::DIR_READ) & rd_req;
    assign tx_pop   = accept;
    assign last_out = accept & (tx_level == LW'(1)) & ~tx_push_ok;
    assign req_d    = ~tx_empty & ~last_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_req  <= 1'b0;
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            rd_req <= req_d;
            if (accept) begin
                dout    <= tx_head;
                dout_en <= 1'b1;
            end else if (evt_valid) begin
                dout_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pfp_rx_ovf.sv
module pfp_rx_ovf (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    input  pfp_pkg::xfer_dir_e evt_dir,
    input  logic               rx_full,
    input  logic               clr,
    input  logic               en,
    output logic               rx_push,
    output logic               flag,
    output logic               irq
);
    logic wr_evt, ovf_set;

    assign wr_evt  = evt_valid & (evt_dir == pfp_pkg::DIR_WRITE);
    assign rx_push = wr_evt & ~rx_full;
    assign ovf_set = wr_evt & rx_full;

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= ovf_set | (flag & ~clr);
    end

    assign irq = flag & en;

endmodule

// File: rtl/strobe_fifo_port.sv
module strobe_fifo_port #(
    parameter int DATA_W = pfp_pkg::PFP_DATA_W,
    parameter int DEPTH  = pfp_pkg::PFP_DEPTH,
    parameter int SYNC   = pfp_pkg::PFP_SYNC,
    parameter int LW     = pfp_pkg::level_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_strb,
    input  logic              ext_dir,
    input  logic [DATA_W-1:0] ext_din,
    output logic [DATA_W-1:0] ext_dout,
    output logic              ext_dout_en,
    output logic              ext_rd_req,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic              tx_full,
    output logic              tx_empty,
    output logic [LW-1:0]     tx_level,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_full,
    output logic              rx_empty,
    output logic [LW-1:0]     rx_level,
    input  logic              ovf_clr,
    input  logic              ovf_en,
    output logic              ovf_flag,
    output logic              ovf_irq
);
    logic               evt_valid;
    pfp_pkg::xfer_dir_e evt_dir;
    logic [DATA_W-1:0]  evt_data;
    logic [DATA_W-1:0]  tx_head;
    logic               tx_pop, rx_push;

    pfp_strobe_sync #(.W(DATA_W), .STAGES(SYNC)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .strb_async (ext_strb),
        .dir_async  (ext_dir),
        .data_async (ext_din),
        .evt_valid  (evt_valid),
        .evt_dir    (evt_dir),
        .evt_data   (evt_data)
    );

    pfp_fifo #(.W(DATA_W), .DEPTH(DEPTH), .LW(LW)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_head),
        .empty (tx_empty),
        .full  (tx_full),
        .level (tx_level)
    );

    pfp_tx_drive #(.W(DATA_W), .LW(LW)) u_txd (
        .clk        (clk),
        .rst        (rst),
        .evt_valid  (evt_valid),
        .evt_dir    (evt_dir),
        .tx_head    (tx_head),
        .tx_empty   (tx_empty),
        .tx_level   (tx_level),
        .tx_push_ok (tx_push & ~tx_full),
        .tx_pop     (tx_pop),
        .rd_req     (ext_rd_req),
        .dout       (ext_dout),
        .dout_en    (ext_dout_en)
    );

    pfp_fifo #(.W(DATA_W), .DEPTH(DEPTH), .LW(LW)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .wdata (evt_data),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .empty (rx_empty),
        .full  (rx_full),
        .level (rx_level)
    );

    pfp_rx_ovf u_ovf (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_dir   (evt_dir),
        .rx_full   (rx_full),
        .clr       (ovf_clr),
        .en        (ovf_en),
        .rx_push   (rx_push),
        .flag      (ovf_flag),
        .irq       (ovf_irq)
    );

endmodule

// File: rtl/strobe_fifo_port_chk.sv
module strobe_fifo_port_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = pfp_pkg::level_bits(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          ext_rd_req,
    input logic          ext_dout_en,
    input logic          tx_empty,
    input logic [LW-1:0] tx_level,
    input logic          rx_full,
    input logic          rx_pop,
    input logic          ovf_clr,
    input logic          ovf_en,
    input logic          ovf_flag,
    input logic          ovf_irq
);
    AST_REQ_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        ext_rd_req |-> !tx_empty); // R4

    AST_REQ_FALLS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_rd_req) |-> tx_empty); // R4

    AST_REQ_RISES_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_rd_req) |-> !$past(tx_empty)); // R5

    AST_DRIVE_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_dout_en) |-> ($past(tx_level) != '0)); // R3

    AST_RX_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rx_pop) |=> rx_full); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !ovf_en |-> !ovf_irq); // R9

    AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        tx_level <= LW'(DEPTH)); // R10

endmodule

bind strobe_fifo_port strobe_fifo_port_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_rd_req  (ext_rd_req),
    .ext_dout_en (ext_dout_en),
    .tx_empty    (tx_empty),
    .tx_level    (tx_level),
    .rx_full     (rx_full),
    .rx_pop      (rx_pop),
    .ovf_clr     (ovf_clr),
    .ovf_en      (ovf_en),
    .ovf_flag    (ovf_flag),
    .ovf_irq     (ovf_irq)
);

// File: tb/strobe_fifo_port_bench.sv
module strobe_fifo_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_strb = 1'b0, ext_dir = 1'b0;
    logic [15:0] ext_din = '0, tx_wdata = '0;
    logic        tx_push = 1'b0, rx_pop = 1'b0, ovf_clr = 1'b0, ovf_en = 1'b0;
    logic [15:0] ext_dout, rx_rdata;
    logic        ext_dout_en, ext_rd_req, tx_full, tx_empty, rx_full, rx_empty;
    logic        ovf_flag, ovf_irq;
    logic [4:0]  tx_level, rx_level;
    int          nchk = 0, nfail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    strobe_fifo_port u_strobe_fifo_port (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] txw(input int n, input int i);
        return {n[7:0], i[7:0]} ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] rxw(input int i);
        return 16'h3C00 + 16'(i * 16'h0111);
    endfunction

    task automatic cpu_push(input logic [15:0] d);
        @(negedge clk); tx_push = 1'b1; tx_wdata = d;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic cpu_pop();
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    // Raise strobe; return after the second system edge (action edge is next).
    task automatic strb_up(input logic rd, input logic [15:0] d);
        @(negedge clk); ext_dir = rd; ext_din = d; ext_strb = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic strb_down(input int extra);
        repeat (extra) @(negedge clk);
        ext_strb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic ext_read(input string req, input logic [15:0] exp_d, input bit last);
        strb_up(1'b1, 16'h0);
        chk("R4", "req before pop", ext_rd_req, 1);
        @(negedge clk);
        chk(req, "dout", ext_dout, exp_d);
        chk("R3", "dout_en", ext_dout_en, 1);
        chk("R4", "req on pop edge", ext_rd_req, !last);
        strb_down(0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "req in reset", ext_rd_req, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "req", ext_rd_req, 0);
        chk("R1", "dout_en", ext_dout_en, 0);
        chk("R1", "tx_empty", tx_empty, 1);
        chk("R1", "rx_empty", rx_empty, 1);
        chk("R1", "full flags", {tx_full, rx_full}, 0);
        chk("R1", "levels", {tx_level, rx_level}, 0);
        chk("R1", "ovf", {ovf_flag, ovf_irq}, 0);

        // Fill/drain sweep over every depth
        for (int n = 1; n <= 16; n++) begin
            for (int i = 0; i < n; i++) begin
                cpu_push(txw(n, i));
                chk("R10", "tx_level", tx_level, i + 1);
                if (i == 0) begin
                    chk("R5", "req right after push", ext_rd_req, 0);
                    @(negedge clk);
                    chk("R5", "req one cycle later", ext_rd_req, 1);
                end
            end
            chk("R10", "tx_full", tx_full, (n == 16));
            for (int i = 0; i < n; i++) begin
                ext_read("R3", txw(n, i), (i == n - 1));
                chk("R3", "tx_level after pop", tx_level, n - i - 1);
            end
            strb_up(1'b1, 16'h0);
            @(negedge clk);
            chk("R6", "dout_en on ignored read", ext_dout_en, 0);
            chk("R6", "tx_level on ignored read", tx_level, 0);
            strb_down(0);
        end

        // Push into full transmit FIFO
        for (int i = 0; i < 17; i++) cpu_push(txw(99, i));
        chk("R10", "tx_level capped", tx_level, 16);
        chk("R10", "tx_full", tx_full, 1);
        for (int i = 0; i < 16; i++) ext_read("R10", txw(99, i), (i == 15));
        chk("R10", "tx_empty after drain", tx_empty, 1);

        // Long strobe gives one transfer
        cpu_push(16'h1234);
        cpu_push(16'h5678);
        @(negedge clk);
        strb_up(1'b1, 16'h0);
        @(negedge clk);
        chk("R2", "first word", ext_dout, 16'h1234);
        strb_down(12);
        chk("R2", "one pop only", tx_level, 1);
        ext_read("R2", 16'h5678, 1'b1);

        // Write strobe drops driver enable and fills receive side
        strb_up(1'b0, 16'hBEEF);
        @(negedge clk);
        chk("R3", "dout_en after write", ext_dout_en, 0);
        chk("R7", "rx_level", rx_level, 1);
        chk("R7", "rx_rdata", rx_rdata, 16'hBEEF);
        strb_down(0);
        cpu_pop();
        chk("R7", "rx_empty", rx_empty, 1);

        for (int i = 0; i < 16; i++) begin
            strb_up(1'b0, rxw(i));
            chk("R7", "rx_level before edge", rx_level, i);
            @(negedge clk);
            chk("R7", "rx_level", rx_level, i + 1);
            chk("R8", "no ovf yet", ovf_flag, 0);
            strb_down(0);
        end
        chk("R7", "rx_full", rx_full, 1);

        strb_up(1'b0, 16'hDEAD);
        @(negedge clk);
        chk("R8", "ovf set", ovf_flag, 1);
        chk("R8", "rx_level held", rx_level, 16);
        strb_down(0);
        chk("R9", "irq masked", ovf_irq, 0);
        @(negedge clk); ovf_en = 1'b1;
        #1 chk("R9", "irq enabled", ovf_irq, 1);

        for (int i = 0; i < 16; i++) begin
            chk("R8", "rx word", rx_rdata, rxw(i));
            cpu_pop();
            chk("R7", "rx_level drain", rx_level, 15 - i);
        end
        cpu_pop();
        chk("R10", "pop on empty", rx_level, 0);
        chk("R10", "rx_empty", rx_empty, 1);
        chk("R9", "flag sticky", ovf_flag, 1);

        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk("R9", "flag cleared", ovf_flag, 0);
        chk("R9", "irq cleared", ovf_irq, 0);

        // Set and clear in the same cycle: set wins
        for (int i = 0; i < 16; i++) begin
            strb_up(1'b0, rxw(i));
            @(negedge clk);
            strb_down(0);
        end
        strb_up(1'b0, 16'hFACE);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R9", "set beats clear", ovf_flag, 1);
        strb_down(0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule